// File: doc/BRIEF.md
# Timestamp Event Queue with Level Interrupt

This block records time-stamped events into a sixteen-entry first-in first-out store and shows the oldest entry through a small register window. Events come from four kinds of source: a software push written through the register port, up to eight hardware strobe inputs (each enabled by its own control bit), and receive or transmit notifications from an Ethernet port that carry a message type, a sequence number, a port number and a domain number. Every entry holds the 64-bit time present on `time_now` when its source fired, a packed event word and a domain word.

Software drains the store by reading the head entry and then writing the pop register. A raw pending bit is high while the store holds anything; the interrupt output is that bit gated by an enable bit. Sources that fire in the same cycle each get a capture slot that latches the time, and an arbiter moves one slot per cycle into the store in a fixed priority order. The store is tracked by a three-state machine: `ST_EMPTY`, `ST_HOLD` (one to fifteen entries) and `ST_FULL`. Transitions: `ST_EMPTY`→`ST_HOLD` on an accepted write; `ST_HOLD`→`ST_FULL` on a write without pop at fifteen entries; `ST_HOLD`→`ST_EMPTY` on a pop without write at one entry; `ST_FULL`→`ST_HOLD` on a pop. All other cases stay put.

Register map (4-bit word address): 0 control (bits 15:8 hardware input enables), 1 interrupt enable (bit 0), 2 raw status (bit 0 pending, bit 1 overflow), 3 masked status (bit 0), 4 push, 5 pop, 6 time low, 7 event word, 8 domain word, 9 time high.

Top module: `tsevt_queue`

## Requirements
- R1: The store holds up to 16 entries and presents them in arrival order; the head entry is read at addresses 6, 7, 8 and 9.
- R2: The event word (address 7) holds the sequence number in bits 15:0, the message type in 19:16, the event type in 23:20 and the port number in 28:24; bits 31:29 read zero.
- R3: The domain word (address 8) holds the domain in bits 7:0 with the upper bits zero.
- R4: Address 6 returns time bits 31:0 and address 9 returns time bits 63:32 of the value latched when the source fired.
- R5: Raw status bit 0 is 1 exactly while the store is non-empty; while it is empty addresses 6 to 9 read zero.
- R6: Masked status bit 0 and the `irq` output both equal raw bit 0 ANDed with interrupt-enable bit 0.
- R7: Writing 1 in bit 0 at address 4 records an event of type 0 with port, message, sequence and domain all zero.
- R8: Control bit 8+k enables hardware input k (k from 0); each rising edge of an enabled input, after a two-stage synchronizer, records one event of type 3 whose port field is k+1; a level held high records nothing more and edges on disabled inputs record nothing.
- R9: Writing 1 in bit 0 at address 5 discards the head entry; doing so while empty has no effect.
- R10: A cycle with `eth_valid` high records an event of type 4 when `eth_is_tx` is 0 and type 5 when it is 1, carrying the given message type, sequence number, port and domain.
- R11: Events fired in the same cycle enter the store in the order software push, hardware inputs from lowest to highest number, then the Ethernet event.
- R12: An event that finds the store full (or its capture slot still occupied) is dropped and raw status bit 1 is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time value to stamp events with |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| hw_in | input | 8 | Asynchronous hardware strobe inputs |
| eth_valid | input | 1 | Ethernet event present this cycle |
| eth_is_tx | input | 1 | 1 transmit, 0 receive |
| eth_msg_type | input | 4 | Message type of the Ethernet event |
| eth_seq_id | input | 16 | Sequence number of the Ethernet event |
| eth_port | input | 5 | Port number of the Ethernet event |
| eth_domain | input | 8 | Domain number of the Ethernet event |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The properties assume the register port carries at most one write per cycle, that `eth_valid` pulses describe complete events, and that `time_now` is a plain value with no relation to the clock the checks rely on. The bench honours this by changing inputs only on falling edges, by holding `time_now` steady during each stimulus phase so expected stamps do not hinge on capture latency, and by lowering hardware inputs for several cycles between tests so every rising edge passes the synchronizer cleanly.

// File: rtl/tsevt_pkg.sv
package tsevt_pkg;

    localparam int TS_W   = 64;
    localparam int ADDR_W = 4;

    typedef enum logic [3:0] {
        EV_PUSH   = 4'd0,
        EV_ROLL   = 4'd1,
        EV_HALF   = 4'd2,
        EV_HWPUSH = 4'd3,
        EV_RX     = 4'd4,
        EV_TX     = 4'd5,
        EV_CMP    = 4'd6,
        EV_HOST   = 4'd7
    } ev_type_e;

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic [4:0]      port;
        ev_type_e        etype;
        logic [3:0]      msg;
        logic [15:0]     seq;
        logic [7:0]      domain;
    } ev_rec_t;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_INTEN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_RAW    = 4'd2;
    localparam logic [ADDR_W-1:0] A_MASKED = 4'd3;
    localparam logic [ADDR_W-1:0] A_PUSH   = 4'd4;
    localparam logic [ADDR_W-1:0] A_POP    = 4'd5;
    localparam logic [ADDR_W-1:0] A_TSLO   = 4'd6;
    localparam logic [ADDR_W-1:0] A_EVW    = 4'd7;
    localparam logic [ADDR_W-1:0] A_DOMW   = 4'd8;
    localparam logic [ADDR_W-1:0] A_TSHI   = 4'd9;

    localparam int HWEN_LSB = 8;

endpackage

// File: rtl/tsevt_sync_edge.sv
module tsevt_sync_edge #(
    parameter int NIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] din,
    input  logic [NIN-1:0] en,
    output logic [NIN-1:0] rise
);

    for (genvar g = 0; g < NIN; g++) begin : g_ch
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= din[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise[g] = sync_q & ~prev_q & en[g];
    end

endmodule

// File: rtl/tsevt_arbiter.sv
module tsevt_arbiter
    import tsevt_pkg::*;
#(
    parameter int NHW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TS_W-1:0]           time_now,
    input  logic                      sw_req,
    input  logic [NHW-1:0]            hw_req,
    input  logic                      eth_req,
    input  logic                      eth_is_tx,
    input  logic [3:0]                eth_msg,
    input  logic [15:0]               eth_seq,
    input  logic [4:0]                eth_port,
    input  logic [7:0]                eth_domain,
    output logic                      wr_valid,
    output ev_rec_t                   wr_rec,
    output logic [NHW+1:0]            grant,
    output logic                      slot_drop
);

    localparam int NSLOT = NHW + 2;
    localparam int SW    = $clog2(NSLOT);
    localparam int ETH_S = NHW + 1;

    logic [NSLOT-1:0] req;
    logic [NSLOT-1:0] pend_q;
    ev_rec_t          nrec  [NSLOT];
    ev_rec_t          rec_q [NSLOT];
    logic [SW-1:0]    gidx;
    logic             found;

    assign req = {eth_req, hw_req, sw_req};

    // Record each source would latch this cycle.
    always_comb begin
        nrec[0] = '{ts: time_now, port: 5'd0, etype: EV_PUSH,
                    msg: 4'd0, seq: 16'd0, domain: 8'd0};
        for (int i = 0; i < NHW; i++) begin
            nrec[i+1] = '{ts: time_now, port: 5'(i + 1), etype: EV_HWPUSH,
                          msg: 4'd0, seq: 16'd0, domain: 8'd0};
        end
        nrec[ETH_S] = '{ts: time_now, port: eth_port,
                        etype: (eth_is_tx ? EV_TX : EV_RX),
                        msg: eth_msg, seq: eth_seq, domain: eth_domain};
    end

    // Fixed priority: lowest slot index wins.
    always_comb begin
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pend_q[i] && !found) begin
                grant[i] = 1'b1;
                gidx     = SW'(i);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NSLOT; i++) rec_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (req[i]) begin
                    if (!pend_q[i] || grant[i]) begin
                        pend_q[i] <= 1'b1;
                        rec_q[i]  <= nrec[i];
                    end
                end else if (grant[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    assign wr_valid  = found;
    assign wr_rec    = rec_q[gidx];
    assign slot_drop = |(req & pend_q & ~grant);

endmodule

// File: rtl/tsevt_fifo_ctl.sv
module tsevt_fifo_ctl
    import tsevt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  ev_rec_t                     wr_rec,
    input  logic                        pop_req,
    input  logic                        slot_drop,
    output ev_rec_t                     head_rec,
    output logic                        not_empty,
    output logic                        overflow,
    output logic [$clog2(DEPTH+1)-1:0]  count
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] C_TOP  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] C_ONE  = CW'(1);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;

    occ_state_e     state_q, state_d;
    ev_rec_t        mem [DEPTH];
    logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]  cnt_q;
    logic           ovf_q;
    logic           do_wr, do_pop;

    assign do_wr  = wr_valid && (state_q != ST_FULL);
    assign do_pop = pop_req  && (state_q != ST_EMPTY);

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (do_wr) state_d = ST_HOLD;
            ST_HOLD: begin
                if (do_wr && !do_pop && cnt_q == C_TOP)      state_d = ST_FULL;
                else if (do_pop && !do_wr && cnt_q == C_ONE) state_d = ST_EMPTY;
            end
            ST_FULL:  if (do_pop) state_d = ST_HOLD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Datapath: pointers, occupancy, sticky overflow.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (do_wr)  wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            if (do_wr && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_wr) cnt_q <= cnt_q - 1'b1;
            if ((wr_valid && state_q == ST_FULL) || slot_drop) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_rec;
    end

    // Outputs.
    always_comb begin
        not_empty = (state_q != ST_EMPTY);
        head_rec  = mem[rd_ptr_q];
        overflow  = ovf_q;
        count     = cnt_q;
    end

endmodule

// File: rtl/tsevt_queue.sv
module tsevt_queue
    import tsevt_pkg::*;
#(
    parameter int NHW   = 8,
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [63:0]          time_now,
    input  logic                 reg_wr,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NHW-1:0]       hw_in,
    input  logic                 eth_valid,
    input  logic                 eth_is_tx,
    input  logic [3:0]           eth_msg_type,
    input  logic [15:0]          eth_seq_id,
    input  logic [4:0]           eth_port,
    input  logic [7:0]           eth_domain,
    output logic                 irq
);

    localparam int NSLOT = NHW + 2;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [NHW-1:0]   hw_en_q;
    logic             inten_q;
    logic [NHW-1:0]   hw_rise;
    logic             sw_req, pop_req;
    logic             wr_valid, slot_drop;
    ev_rec_t          wr_rec, head_rec;
    logic [NSLOT-1:0] grant;
    logic             not_empty, overflow;
    logic [CW-1:0]    count;
    logic [31:0]      ev_word, dom_word;

    assign sw_req  = reg_wr && reg_addr == A_PUSH && reg_wdata[0];
    assign pop_req = reg_wr && reg_addr == A_POP  && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_en_q <= '0;
            inten_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL)  hw_en_q <= reg_wdata[HWEN_LSB +: NHW];
            if (reg_addr == A_INTEN) inten_q <= reg_wdata[0];
        end
    end

    tsevt_sync_edge #(.NIN(NHW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hw_in),
        .en    (hw_en_q),
        .rise  (hw_rise)
    );

    tsevt_arbiter #(.NHW(NHW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_now   (time_now),
        .sw_req     (sw_req),
        .hw_req     (hw_rise),
        .eth_req    (eth_valid),
        .eth_is_tx  (eth_is_tx),
        .eth_msg    (eth_msg_type),
        .eth_seq    (eth_seq_id),
        .eth_port   (eth_port),
        .eth_domain (eth_domain),
        .wr_valid   (wr_valid),
        .wr_rec     (wr_rec),
        .grant      (grant),
        .slot_drop  (slot_drop)
    );

    tsevt_fifo_ctl #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_rec    (wr_rec),
        .pop_req   (pop_req),
        .slot_drop (slot_drop),
        .head_rec  (head_rec),
        .not_empty (not_empty),
        .overflow  (overflow),
        .count     (count)
    );

    assign ev_word  = {3'b000, head_rec.port, head_rec.etype, head_rec.msg, head_rec.seq};
    assign dom_word = {24'd0, head_rec.domain};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:   reg_rdata[HWEN_LSB +: NHW] = hw_en_q;
            A_INTEN:  reg_rdata[0] = inten_q;
            A_RAW:    reg_rdata[1:0] = {overflow, not_empty};
            A_MASKED: reg_rdata[0] = not_empty & inten_q;
            A_TSLO:   reg_rdata = not_empty ? head_rec.ts[31:0]  : '0;
            A_EVW:    reg_rdata = not_empty ? ev_word            : '0;
            A_DOMW:   reg_rdata = not_empty ? dom_word           : '0;
            A_TSHI:   reg_rdata = not_empty ? head_rec.ts[63:32] : '0;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = not_empty & inten_q;

endmodule

// File: rtl/tsevt_queue_chk.sv
module tsevt_queue_chk #(
    parameter int DEPTH = 16,
    parameter int NSLOT = 10,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             inten_q,
    input logic             not_empty,
    input logic [CW-1:0]    count,
    input logic [NSLOT-1:0] grant,
    input logic             overflow,
    input logic             wr_valid,
    input logic             pop_req
);

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (not_empty && inten_q));

    assert_pending_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        not_empty == (count != '0));

    assert_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) == wr_valid);

    assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !wr_valid) |=> count == '0);

    assert_full_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !pop_req) |=> count == CW'(DEPTH));

endmodule

bind tsevt_queue tsevt_queue_chk #(
    .DEPTH (DEPTH),
    .NSLOT (NSLOT),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .inten_q   (inten_q),
    .not_empty (not_empty),
    .count     (count),
    .grant     (grant),
    .overflow  (overflow),
    .wr_valid  (wr_valid),
    .pop_req   (pop_req)
);

// File: tb/tsevt_queue_tb_top.sv
module tsevt_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NHW        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NHW-1:0] hw_in = '0;
    logic        eth_valid = 1'b0;
    logic        eth_is_tx = 1'b0;
    logic [3:0]  eth_msg_type = '0;
    logic [15:0] eth_seq_id = '0;
    logic [4:0]  eth_port = '0;
    logic [7:0]  eth_domain = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [63:0] ts;
        logic [31:0] w1;
        logic [31:0] w2;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsevt_queue dut_i (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hw_in(hw_in),
        .eth_valid(eth_valid), .eth_is_tx(eth_is_tx),
        .eth_msg_type(eth_msg_type), .eth_seq_id(eth_seq_id),
        .eth_port(eth_port), .eth_domain(eth_domain), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_w1(input logic [4:0] port, input logic [3:0] ty,
                                          input logic [3:0] msg, input logic [15:0] seq);
        return {3'b000, port, ty, msg, seq};
    endfunction

    // Driver side: expected items for the scoreboard.
    task automatic expect_ev(input logic [63:0] ts, input logic [31:0] w1, input logic [7:0] dom);
        exp_t e;
        e.ts = ts; e.w1 = w1; e.w2 = {24'd0, dom};
        exp_q.push_back(e);
    endtask

    task automatic sw_push(input logic [63:0] t);
        @(negedge clk);
        time_now = t; reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_ev(t, mk_w1(5'd0, 4'd0, 4'd0, 16'd0), 8'd0);   // R7
    endtask

    task automatic eth_ev(input logic [63:0] t, input logic tx, input logic [3:0] m,
                          input logic [15:0] s, input logic [4:0] p, input logic [7:0] d);
        @(negedge clk);
        time_now = t; eth_valid = 1'b1; eth_is_tx = tx;
        eth_msg_type = m; eth_seq_id = s; eth_port = p; eth_domain = d;
        @(negedge clk);
        eth_valid = 1'b0;
        expect_ev(t, mk_w1(p, tx ? 4'd5 : 4'd4, m, s), d);     // R10
    endtask

    // Monitor side: read head, compare with queue front, pop.
    task automatic drain(input string req);
        logic [31:0] raw, lo, hi, w1, w2;
        exp_t e;
        for (int guard = 0; guard < 40; guard++) begin
            rd(4'd2, raw);
            if (!raw[0]) break;
            rd(4'd6, lo); rd(4'd9, hi); rd(4'd7, w1); rd(4'd8, w2);
            if (exp_q.size() == 0) begin
                check(1'b0, {req, " unexpected entry"}, {hi, lo}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                check({hi, lo} == e.ts, {req, " R4 time"}, {hi, lo}, e.ts);
                check(w1 == e.w1 && w2 == e.w2, {req, " R2 R3 words"}, {w1, w2}, {e.w1, e.w2});
            end
            wr(4'd5, 32'd1);
        end
        check(exp_q.size() == 0, {req, " R1 missing entries"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // Reset state (R5, R6)
        rd(4'd2, d); check(d == 32'd0, "R5 raw at reset", d, 0);
        rd(4'd3, d); check(d == 32'd0, "R6 masked at reset", d, 0);
        check(irq == 1'b0, "R6 irq at reset", irq, 0);
        rd(4'd7, d); check(d == 32'd0, "R5 event word empty", d, 0);

        // Software push and interrupt gating (R7, R5, R6, R4)
        sw_push(64'h1234_5678_9ABC_DEF0);
        idle(2);
        rd(4'd2, d); check(d[0] == 1'b1, "R5 pending set", d, 1);
        check(irq == 1'b0, "R6 irq masked off", irq, 0);
        wr(4'd1, 32'd1);
        rd(4'd3, d); check(d[0] == 1'b1, "R6 masked set", d, 1);
        check(irq == 1'b1, "R6 irq raised", irq, 1);
        drain("R7 push");
        rd(4'd2, d); check(d[0] == 1'b0, "R5 pending cleared", d, 0);
        check(irq == 1'b0, "R6 irq dropped", irq, 0);

        // Disabled hardware input is ignored (R8)
        time_now = 64'h55;
        hw_in[1] = 1'b1; idle(6); hw_in[1] = 1'b0; idle(6);
        rd(4'd2, d); check(d[0] == 1'b0, "R8 disabled input ignored", d, 0);

        // Enabled input 4 (bit 12), held high: one event, port 5 (R8)
        wr(4'd0, 32'h0000_1000);
        rd(4'd0, d); check(d == 32'h0000_1000, "R8 control readback", d, 32'h1000);
        time_now = 64'hAAAA_0000_0000_0042;
        hw_in[4] = 1'b1; idle(12); hw_in[4] = 1'b0; idle(4);
        expect_ev(64'hAAAA_0000_0000_0042, mk_w1(5'd5, 4'd3, 4'd0, 16'd0), 8'd0);
        drain("R8 hw edge");

        // Ethernet receive and transmit (R10, R2, R3)
        eth_ev(64'h0000_0001_0000_0002, 1'b0, 4'hB, 16'hBEEF, 5'd17, 8'hC3);
        eth_ev(64'hFFFF_FFFF_0000_0007, 1'b1, 4'h3, 16'h0102, 5'd2, 8'h7E);
        idle(3);
        drain("R10 eth");

        // Same-cycle sources: push, hw 1, hw 3, eth (R11)
        wr(4'd0, 32'h0000_0500);
        idle(4);
        time_now = 64'h0000_0000_0000_0900;
        @(negedge clk); hw_in[0] = 1'b1; hw_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
        eth_valid = 1'b1; eth_is_tx = 1'b1; eth_msg_type = 4'h1;
        eth_seq_id = 16'h0033; eth_port = 5'd4; eth_domain = 8'h09;
        @(negedge clk);
        reg_wr = 1'b0; eth_valid = 1'b0;
        idle(6);
        hw_in = '0;
        expect_ev(64'h900, mk_w1(5'd0, 4'd0, 4'd0, 16'd0), 8'd0);
        expect_ev(64'h900, mk_w1(5'd1, 4'd3, 4'd0, 16'd0), 8'd0);
        expect_ev(64'h900, mk_w1(5'd3, 4'd3, 4'd0, 16'd0), 8'd0);
        expect_ev(64'h900, mk_w1(5'd4, 4'd5, 4'h1, 16'h0033), 8'h09);
        drain("R11 priority");
        wr(4'd0, 32'd0);
        idle(4);

        // Pop while empty has no effect (R9)
        wr(4'd5, 32'd1);
        sw_push(64'h77);
        idle(2);
        wr(4'd5, 32'd1);
        wr(4'd5, 32'd1);
        rd(4'd2, d); check(d[0] == 1'b0, "R9 pop removes head", d, 0);
        exp_q.delete();
        sw_push(64'h88);
        idle(2);
        drain("R9 after empty pop");

        // Fill past depth: 17th dropped, overflow sticky (R1, R12)
        rd(4'd2, d); check(d[1] == 1'b0, "R12 overflow clear before fill", d, 0);
        for (int k = 0; k < 17; k++) sw_push(64'h1000 + 64'(k));
        idle(3);
        void'(exp_q.pop_back());
        rd(4'd2, d); check(d[1:0] == 2'b11, "R12 overflow set when full", d, 3);
        drain("R1 fill order");
        rd(4'd2, d); check(d[1:0] == 2'b10, "R12 overflow sticky after drain", d, 2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule